// File: doc/BRIEF.md
# Bipolar Stochastic Mean-of-Products Synapse Unit

This unit computes one neuron input in stochastic bit-stream arithmetic. Every signed quantity in [-1, +1] travels as a serial bit stream in which the chance of a 1 equals (v + 1) / 2. Each clock the unit receives one bit from each of four weight streams and one bit from each of four activation streams. It forms the signed product of every weight/activation pair with an equivalence (XNOR) gate.

The unit does not add the four products, because a sum could leave the representable range. Instead it takes one product per clock, chosen by a 2-bit index that an external uniform random source supplies. Over time the output stream therefore carries the arithmetic mean of the four products, which always stays inside [-1, +1]. The chosen bit is registered before it leaves the block.

The random select source, the nonlinearity and the conversion between numbers and streams all sit outside this block.

Top module: `stoch_mean_synapse`

## Requirements
- R1: While `rst_ni` is low, `mean_o` is 0. Asserting `rst_ni` low clears `mean_o` at once, without waiting for a clock edge.
- R2: A lane's product bit is 1 when its weight bit and activation bit are equal, and 0 when they differ (bipolar multiply, where 1 stands for +1 and 0 stands for -1).
- R3: `sel_i` is a binary lane index: value k (0..3) selects the product of `weight_i[k]` and `act_i[k]`.
- R4: `mean_o` after a rising clock edge equals the product bit that was selected at that edge. This gives one cycle of latency, and back-to-back inputs give back-to-back results.
- R5: The weight and activation bits of lanes that `sel_i` does not select have no effect on `mean_o`.
- R6: With `sel_i` uniform over the four lanes, the mean of the output stream is the mean of the four products. Round-robin selection over products 1,1,1,0 gives exactly three ones in every four cycles. Over 4096 cycles of independent random streams, the measured bipolar mean is within 0.05 of the average of the ideal products.
- R7: The first rising edge after `rst_ni` goes high already registers that cycle's selected product, so no dead cycle follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| weight_i | input | 4 | One bit per lane from the weight streams |
| act_i | input | 4 | One bit per lane from the activation streams |
| sel_i | input | 2 | Random lane index, uniform and independent of the data |
| mean_o | output | 1 | Registered output stream bit |

## Verification
Every per-cycle result is due exactly one rising edge after the inputs that produce it are applied. A reset result is due immediately after `rst_ni` falls. The driver applies inputs on the falling edge and queues the expected bit. The monitor takes that bit from the queue shortly after the next rising edge, so every comparison lands in the cycle where the register has just updated. The stream-mean checks count output ones over whole windows only after the queue has drained. The immediate-clear check samples one time unit after the mid-cycle reset edge.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int unsigned LANES = 4;
  localparam int unsigned SEL_W = $clog2(LANES);
endpackage

// File: rtl/ssu_product_lanes.sv
module ssu_product_lanes #(
  parameter int unsigned N_LANES = ssu_pkg::LANES
) (
  input  logic [N_LANES-1:0] weight_i,
  input  logic [N_LANES-1:0] act_i,
  output logic [N_LANES-1:0] prod_o
);
  // bipolar multiply: equal bits -> +1
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign prod_o[g] = ~(weight_i[g] ^ act_i[g]);
  end
endmodule

// File: rtl/ssu_rand_select.sv
module ssu_rand_select #(
  parameter int unsigned N_LANES = ssu_pkg::LANES,
  parameter int unsigned SEL_W   = ssu_pkg::SEL_W
) (
  input  logic [N_LANES-1:0] prod_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               pick_o
);
  always_comb begin
    pick_o = 1'b0;
    for (int k = 0; k < N_LANES; k++) begin
      if (sel_i == SEL_W'(k)) pick_o = prod_i[k];
    end
  end
endmodule

// File: rtl/ssu_out_reg.sv
module ssu_out_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/stoch_mean_synapse.sv
module stoch_mean_synapse #(
  parameter int unsigned N_LANES = ssu_pkg::LANES,
  localparam int unsigned SEL_W  = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LANES-1:0] weight_i,
  input  logic [N_LANES-1:0] act_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               mean_o
);
  logic [N_LANES-1:0] prod;
  logic               pick;

  ssu_product_lanes #(.N_LANES(N_LANES)) i_lanes (
    .weight_i (weight_i),
    .act_i    (act_i),
    .prod_o   (prod)
  );

  ssu_rand_select #(.N_LANES(N_LANES), .SEL_W(SEL_W)) i_sel (
    .prod_i (prod),
    .sel_i  (sel_i),
    .pick_o (pick)
  );

  ssu_out_reg i_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pick),
    .q_o    (mean_o)
  );

  // checker state: previous edge was taken out of reset
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_LANE_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> mean_o == $past(~(weight_i[sel_i] ^ act_i[sel_i]))); // R4
  AST_MATCH_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(weight_i[sel_i] == act_i[sel_i]) |-> mean_o); // R2
  AST_MISMATCH_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(weight_i[sel_i] != act_i[sel_i]) |-> !mean_o); // R2
  AST_UNANIMOUS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past((weight_i ~^ act_i) == '1) |-> mean_o); // R5
  AST_UNANIMOUS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past((weight_i ^ act_i) == '1) |-> !mean_o); // R5
endmodule

// File: tb/test_stoch_mean_synapse.sv
module test_stoch_mean_synapse;
  localparam int N  = 4;
  localparam int SW = 2;
  localparam int STAT_CYC = 4096;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  weight_i = '0;
  logic [N-1:0]  act_i = '0;
  logic [SW-1:0] sel_i = '0;
  logic          mean_o;

  stoch_mean_synapse i_stoch_mean_synapse (
    .clk_i, .rst_ni, .weight_i, .act_i, .sel_i, .mean_o
  );

  always #2 clk_i = ~clk_i;

  typedef struct {
    logic  exp;
    string tag;
    bit    tally;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0, ones = 0;
  bit done = 0;

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: mean_o=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [N-1:0] w, input logic [N-1:0] a,
                       input logic [SW-1:0] s, input string tag, input bit tally);
    item_t it;
    @(negedge clk_i);
    weight_i = w; act_i = a; sel_i = s;
    it.exp = ~(w[s] ^ a[s]);
    it.tag = tag;
    it.tally = tally;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(posedge clk_i);
    #2;
  endtask

  // monitor: result due one edge after drive
  always @(posedge clk_i) begin
    item_t it;
    #1;
    if (sb_q.size() != 0) begin
      it = sb_q.pop_front();
      check(it.tag, mean_o, it.exp);
      if (it.tally && mean_o === 1'b1) ones++;
    end
  end

  function automatic logic [31:0] rng_step(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] st;
    int w_thr[N];
    int a_thr[N];
    real ideal, meas, diff;
    w_thr = '{49152, 8192, 40960, 16384};
    a_thr = '{58982, 52429, 0, 49152};

    // R1: reset state
    repeat (4) @(negedge clk_i);
    check("R1 reset", mean_o, 1'b0);
    rst_ni = 1'b1;

    // R7: first edge after release registers data
    drive(4'b0001, 4'b0001, 2'd0, "R7 first edge", 0);

    // R2: equivalence truth table on lane 1
    for (int c = 0; c < 4; c++)
      drive(4'(c[0]) << 1, 4'(c[1]) << 1, 2'd1, "R2 xnor", 0);

    // R3: one-hot products, sweep index
    for (int s = 0; s < N; s++)
      for (int k = 0; k < N; k++)
        drive(4'b0000, ~(4'b0001 << k), SW'(s), "R3 index", 0);

    // R5: lane 2 fixed at +1, others swept
    for (int v = 0; v < 64; v++) begin
      logic [N-1:0] w, a;
      w = {v[0], 1'b1, v[1], v[2]};
      a = {v[3], 1'b1, v[4], v[5]};
      drive(w, a, 2'd2, "R5 unselected", 0);
    end
    // R5: lane 0 fixed at -1, others forced to +1
    for (int v = 0; v < 8; v++)
      drive({3'(v), 1'b0}, {3'(v), 1'b1}, 2'd0, "R5 unselected", 0);

    // R4: back-to-back alternating results
    for (int c = 0; c < 16; c++)
      drive(4'b1010, 4'b1010 ^ 4'(c & 1), 2'd0, "R4 latency", 0);
    drain();

    // R1: asynchronous clear mid-cycle
    drive(4'b1111, 4'b1111, 2'd3, "R4 latency", 0);
    drain();
    check("R4 before reset", mean_o, 1'b1);
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", mean_o, 1'b0);
    repeat (2) @(negedge clk_i);
    check("R1 held in reset", mean_o, 1'b0);
    rst_ni = 1'b1;

    // R6: round-robin over products 1,1,1,0 -> exactly 3/4 ones
    ones = 0;
    for (int c = 0; c < 256; c++)
      drive(4'b0111, 4'b1111, SW'(c), "R4 latency", 1);
    drain();
    n_chk++;
    if (ones != 192) begin
      n_fail++;
      $display("FAIL R6 round-robin: ones=%0d expected 192", ones);
    end

    // R6: stochastic mean over seeded random streams
    ideal = 0.0;
    for (int k = 0; k < N; k++)
      ideal += (2.0 * w_thr[k] / 65536.0 - 1.0) * (2.0 * a_thr[k] / 65536.0 - 1.0);
    ideal = ideal / N;
    ones = 0;
    st = 32'h2545_F491;
    for (int c = 0; c < STAT_CYC; c++) begin
      logic [N-1:0] w, a;
      logic [SW-1:0] s;
      for (int k = 0; k < N; k++) begin
        st = rng_step(st); w[k] = (int'(st[15:0]) < w_thr[k]);
        st = rng_step(st); a[k] = (int'(st[15:0]) < a_thr[k]);
      end
      st = rng_step(st); s = st[20:19];
      drive(w, a, s, "R4 latency", 1);
    end
    drain();
    meas = 2.0 * ones / STAT_CYC - 1.0;
    diff = meas - ideal;
    if (diff < 0.0) diff = -diff;
    n_chk++;
    if (diff > 0.05) begin
      n_fail++;
      $display("FAIL R6 stochastic mean: measured %f expected %f", meas, ideal);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule